// File: doc/BRIEF.md
# Wave-Table Playback Channel

This block plays back a short user-drawn waveform. The waveform has 32 four-bit samples, packed two to a byte into a 16-byte sample store. A small byte-wide register bus writes and reads the sample store. The same bus writes five control registers: converter enable, length preset, output level, period low byte, and period high bits with the start and length-stop controls. A CPU-cycle clock enable drives an internal period timer. Each time the timer runs out, the next sample is fetched, scaled by a coarse level code, and held on the output until the next fetch.

A small state machine has two states. `CH_IDLE` means the channel is silent. `CH_RUN` means the channel is playing. It moves from `CH_IDLE` to `CH_RUN` on a start command. A start command while in `CH_RUN` stays in `CH_RUN` and restarts playback. It moves from `CH_RUN` back to `CH_IDLE` when the length counter wraps while length-stop is set. The length counter is advanced by a length strobe supplied from outside. The sample is audible only when the channel is in `CH_RUN` and the converter enable is on. The status flag reports exactly that condition. Mixing with other channels happens elsewhere.

Address map, 5-bit address:
- Bit 4 set selects sample-store byte `addr[3:0]`.
- Bit 4 clear selects a control register by `addr[2:0]`:
  - 0: converter enable.
  - 1: length preset.
  - 2: level.
  - 3: period low byte.
  - 4: control.

Top module: `wavech_top`

## Requirements
- R1: After reset the status flag is 0, the sample output is 0, and every sample-store byte reads back as 0.
- R2: A write with address bit 4 set stores the data byte at index `addr[3:0]`. A read with bit 4 set returns that byte combinationally. Reads with bit 4 clear return 8'hFF.
- R3: A write to the control register (address 4) with bit 7 set starts the channel. The sample output is cleared, the position is set to 0, and the timer is loaded with 3. The first sample (position 0) therefore appears after the third enabled cycle that follows.
- R4: The period is 11 bits. Its low byte is register 3 and its top three bits are control bits 2:0. After each expiry the timer reloads with (2048 − period) × 2 enabled cycles.
- R5: At each expiry the sample is taken from byte `position >> 1`. An even position takes bits 7:4 and an odd position takes bits 3:0. The 5-bit position then advances and wraps from 31 to 0.
- R6: The level code sits in bits 6:5 of register 2. Code 0 mutes, 1 passes the sample, 2 shifts it right by one, and 3 shifts it right by two. The code is applied when the sample is fetched.
- R7: The converter enable is bit 7 of register 0. The output is 0 and the status flag is 0 unless the channel is running and the converter is on. Turning the converter off does not stop the position from advancing.
- R8: Writing register 1 loads the 8-bit length counter. Each length strobe in `CH_RUN` adds one. When the counter wraps from 255 to 0, the channel returns to `CH_IDLE` if length-stop (control bit 6) is set, and keeps running otherwise.
- R9: While the cycle enable is low, the timer and position hold and the output does not change.
- R10: A start command while the channel is running restarts playback from position 0 with the 3-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | CPU-cycle enable for the period timer |
| len_tick | input | 1 | Length counter strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register / sample-store address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sample_out | output | 4 | Scaled current sample |
| active | output | 1 | Channel running with converter on |

## Verification
The hardest case to reach from the ports is a fetch that happens while the converter is off. The position must keep advancing silently, so the sample that appears after the converter is switched back on belongs to a later position. The stimulus starts playback at a fast period, turns the converter off and on at known cycles, and predicts the first audible position from the expiry schedule. Length-stop is reached by preloading the counter to 254, so only two strobes are needed to reach the wrap.

// File: rtl/wavech_pkg.sv
package wavech_pkg;

    // control register selects (address bit 4 clear)
    localparam logic [2:0] SEL_DAC = 3'd0;
    localparam logic [2:0] SEL_LEN = 3'd1;
    localparam logic [2:0] SEL_LVL = 3'd2;
    localparam logic [2:0] SEL_PLO = 3'd3;
    localparam logic [2:0] SEL_CTL = 3'd4;

    // bit positions that other logic decodes
    localparam int DAC_BIT  = 7;
    localparam int START_BIT = 7;
    localparam int STOP_BIT = 6;
    localparam int LVL_LSB  = 5;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    function automatic logic [3:0] level_scale(input logic [3:0] nib, input logic [1:0] code);
        logic [3:0] r;
        unique case (code)
            2'd0:    r = 4'd0;
            2'd1:    r = nib;
            2'd2:    r = nib >> 1;
            default: r = nib >> 2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wavech_regs.sv
module wavech_regs
    import wavech_pkg::*;
#(
    parameter int RAM_BYTES = 16,
    parameter int WL_W      = 11,
    parameter int LEN_W     = 8,
    localparam int IDX_W    = $clog2(RAM_BYTES),
    localparam int ADDR_W   = IDX_W + 1,
    localparam int HI_W     = WL_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [IDX_W-1:0]  fetch_idx,
    output logic [7:0]        fetch_byte,
    output logic              dac_on,
    output logic [1:0]        level,
    output logic [WL_W-1:0]   period,
    output logic              len_stop,
    output logic              len_load,
    output logic [LEN_W-1:0]  len_val,
    output logic              start
);

    logic [7:0]      store_q [RAM_BYTES];
    logic [7:0]      plo_q;
    logic [HI_W-1:0] phi_q;
    logic            dac_q;
    logic [1:0]      lvl_q;
    logic            stop_q;

    logic            wave_sel;
    logic            ctl_wr;
    logic [2:0]      sel;

    always_comb begin
        wave_sel = bus_addr[ADDR_W-1];
        sel      = bus_addr[2:0];
        ctl_wr   = bus_we && !wave_sel;
    end

    // sample store
    always_ff @(posedge clk) begin
        for (int i = 0; i < RAM_BYTES; i++) begin
            if (!rst_n) begin
                store_q[i] <= 8'd0;
            end else if (bus_we && wave_sel && bus_addr[IDX_W-1:0] == IDX_W'(i)) begin
                store_q[i] <= bus_wdata;
            end
        end
    end

    // control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q  <= 1'b0;
            lvl_q  <= 2'd0;
            plo_q  <= 8'd0;
            phi_q  <= '0;
            stop_q <= 1'b0;
        end else if (ctl_wr) begin
            unique case (sel)
                SEL_DAC: dac_q <= bus_wdata[DAC_BIT];
                SEL_LVL: lvl_q <= bus_wdata[LVL_LSB+1:LVL_LSB];
                SEL_PLO: plo_q <= bus_wdata;
                SEL_CTL: begin
                    phi_q  <= bus_wdata[HI_W-1:0];
                    stop_q <= bus_wdata[STOP_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata  = wave_sel ? store_q[bus_addr[IDX_W-1:0]] : 8'hFF;
        fetch_byte = store_q[fetch_idx];
        dac_on     = dac_q;
        level      = lvl_q;
        period     = {phi_q, plo_q};
        len_stop   = stop_q;
        len_load   = ctl_wr && sel == SEL_LEN;
        len_val    = bus_wdata[LEN_W-1:0];
        start      = ctl_wr && sel == SEL_CTL && bus_wdata[START_BIT];
    end

endmodule

// File: rtl/wavech_fsm.sv
module wavech_fsm
    import wavech_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             len_tick,
    input  logic             len_load,
    input  logic [LEN_W-1:0] len_val,
    input  logic             len_stop,
    output logic             running
);

    localparam logic [LEN_W-1:0] LEN_LAST = '1;

    ch_state_e        st_q, st_d;
    logic [LEN_W-1:0] len_q;
    logic             len_wrap;

    always_comb begin
        len_wrap = len_tick && !len_load && st_q == CH_RUN && len_q == LEN_LAST;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: if (start) st_d = CH_RUN;
            CH_RUN: begin
                if (start)                     st_d = CH_RUN;
                else if (len_wrap && len_stop) st_d = CH_IDLE;
            end
            default: st_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // length counter
    always_ff @(posedge clk) begin
        if (!rst_n)                          len_q <= '0;
        else if (len_load)                   len_q <= len_val;
        else if (len_tick && st_q == CH_RUN) len_q <= len_q + 1'b1;
    end

    // outputs
    always_comb begin
        running = (st_q == CH_RUN);
    end

endmodule

// File: rtl/wavech_timer.sv
module wavech_timer #(
    parameter int WL_W       = 11,
    parameter int POS_W      = 5,
    parameter int TRIG_DELAY = 3,
    localparam int TMR_W     = WL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             running,
    input  logic             start,
    input  logic [WL_W-1:0]  period,
    output logic [POS_W-1:0] pos,
    output logic             expire
);

    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W-1:0] span;
    logic [TMR_W-1:0] reload;
    logic [POS_W-1:0] pos_q;

    always_comb begin
        span   = {2'b01, {WL_W{1'b0}}} - {2'b00, period};
        reload = span << 1;
        expire = running && cyc_en && !start && (tmr_q <= TMR_W'(1));
        pos    = pos_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            pos_q <= '0;
        end else if (start) begin
            tmr_q <= TMR_W'(TRIG_DELAY);
            pos_q <= '0;
        end else if (expire) begin
            tmr_q <= reload;
            pos_q <= pos_q + 1'b1;
        end else if (running && cyc_en) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

endmodule

// File: rtl/wavech_dac.sv
module wavech_dac
    import wavech_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       expire,
    input  logic       running,
    input  logic       dac_on,
    input  logic [1:0] level,
    input  logic [7:0] fetch_byte,
    input  logic       odd_pos,
    output logic [3:0] sample_out,
    output logic       active
);

    logic [3:0] hold_q;
    logic [3:0] nib;
    logic       audible;

    always_comb begin
        nib     = odd_pos ? fetch_byte[3:0] : fetch_byte[7:4];
        audible = running && dac_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 4'd0;
        else if (start)  hold_q <= 4'd0;
        else if (expire) hold_q <= audible ? level_scale(nib, level) : 4'd0;
    end

    always_comb begin
        active     = audible;
        sample_out = audible ? hold_q : 4'd0;
    end

endmodule

// File: rtl/wavech_top.sv
module wavech_top #(
    parameter int RAM_BYTES  = 16,
    parameter int WL_W       = 11,
    parameter int LEN_W      = 8,
    parameter int TRIG_DELAY = 3,
    localparam int IDX_W     = $clog2(RAM_BYTES),
    localparam int POS_W     = IDX_W + 1,
    localparam int ADDR_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              len_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [3:0]        sample_out,
    output logic              active
);

    logic [7:0]       fetch_byte;
    logic             dac_on;
    logic [1:0]       level;
    logic [WL_W-1:0]  period;
    logic             len_stop;
    logic             len_load;
    logic [LEN_W-1:0] len_val;
    logic             start_w;
    logic             running;
    logic [POS_W-1:0] pos_w;
    logic             expire_w;

    wavech_regs #(.RAM_BYTES(RAM_BYTES), .WL_W(WL_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fetch_idx(pos_w[POS_W-1:1]), .fetch_byte(fetch_byte),
        .dac_on(dac_on), .level(level), .period(period), .len_stop(len_stop),
        .len_load(len_load), .len_val(len_val), .start(start_w)
    );

    wavech_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_w), .len_tick(len_tick),
        .len_load(len_load), .len_val(len_val), .len_stop(len_stop),
        .running(running)
    );

    wavech_timer #(.WL_W(WL_W), .POS_W(POS_W), .TRIG_DELAY(TRIG_DELAY)) u_timer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .running(running),
        .start(start_w), .period(period), .pos(pos_w), .expire(expire_w)
    );

    wavech_dac u_dac (
        .clk(clk), .rst_n(rst_n), .start(start_w), .expire(expire_w),
        .running(running), .dac_on(dac_on), .level(level),
        .fetch_byte(fetch_byte), .odd_pos(pos_w[0]),
        .sample_out(sample_out), .active(active)
    );

endmodule

// File: rtl/wavech_chk.sv
module wavech_chk #(
    parameter int POS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_en,
    input logic             len_tick,
    input logic             bus_we,
    input logic [3:0]       sample_out,
    input logic             active,
    input logic             start,
    input logic             expire,
    input logic [POS_W-1:0] play_pos
);

    // R7: silent whenever not audible
    assert_silent_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sample_out == 4'd0);

    // R3 / R10: a start clears the held sample
    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> sample_out == 4'd0);

    // R9: nothing moves without enable, bus write or length strobe
    assert_hold_without_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !bus_we && !len_tick) |=> ($stable(sample_out) && $stable(active)));

    // R8: the flag only drops after a bus write or a length strobe
    assert_stop_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(bus_we || len_tick));

    // R5: position moves only at an expiry or a start
    assert_pos_only_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !start) |=> $stable(play_pos));

endmodule

bind wavech_top wavech_chk #(.POS_W(POS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .len_tick(len_tick),
    .bus_we(bus_we), .sample_out(sample_out), .active(active),
    .start(start_w), .expire(expire_w), .play_pos(pos_w)
);

// File: tb/wavech_top_bench.sv
`timescale 1ns/1ps
module wavech_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       len_tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] sample_out;
    logic       active;

    always #2 clk = ~clk;

    wavech_top u_wavech_top (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .len_tick(len_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sample_out(sample_out), .active(active)
    );

    int total = 0;
    int bad = 0;
    int edge_n = 0;
    bit finished = 0;
    logic [7:0] model_ram [16];
    logic [1:0] model_lvl = 2'd1;

    typedef struct {
        int         stamp;
        int         req;
        bit         chk_smp;
        logic [3:0] smp;
        bit         act;
    } exp_t;
    exp_t sb_q[$];

    always @(posedge clk) edge_n++;

    // monitor: pops expected items as their cycle arrives
    always @(negedge clk) begin
        exp_t e;
        while (sb_q.size() > 0 && sb_q[0].stamp <= edge_n) begin
            e = sb_q.pop_front();
            total++;
            if (e.stamp != edge_n || active !== e.act || (e.chk_smp && sample_out !== e.smp)) begin
                bad++;
                $display("FAIL R%0d cycle %0d (due %0d): sample=%0d active=%0b expected sample=%0d active=%0b",
                         e.req, edge_n, e.stamp, sample_out, active, e.smp, e.act);
            end
        end
    end

    function automatic logic [3:0] nib_of(input int p);
        logic [7:0] b;
        b = model_ram[(p % 32) >> 1];
        return (p % 2 == 0) ? b[7:4] : b[3:0];
    endfunction

    function automatic logic [3:0] scaled(input logic [3:0] n, input logic [1:0] c);
        case (c)
            2'd0:    return 4'd0;
            2'd1:    return n;
            2'd2:    return n >> 1;
            default: return n >> 2;
        endcase
    endfunction

    task automatic push(input int stamp, input int req, input bit chk, input logic [3:0] smp, input bit act);
        exp_t e;
        e.stamp = stamp; e.req = req; e.chk_smp = chk; e.smp = smp; e.act = act;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_rd(input logic [4:0] a, input logic [7:0] exp_d, input int req);
        @(negedge clk);
        bus_addr = a;
        #1;
        total++;
        if (bus_rdata !== exp_d) begin
            bad++;
            $display("FAIL R%0d read addr %0h: got %02h expected %02h", req, a, bus_rdata, exp_d);
        end
    endtask

    task automatic pulse_len();
        @(negedge clk); len_tick = 1'b1;
        @(negedge clk); len_tick = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // expected fetches after a start at edge t with reload r
    task automatic play(input int t, input int r, input int n, input int req);
        for (int k = 0; k < n; k++) begin
            push(t + 3 + k * r, (k == 0) ? 3 : req, 1'b1, scaled(nib_of(k), model_lvl), 1'b1);
            if (r > 1) push(t + 4 + k * r, req, 1'b1, scaled(nib_of(k), model_lvl), 1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t, d, e, x, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        total++;
        if (active !== 1'b0 || sample_out !== 4'd0) begin
            bad++;
            $display("FAIL R1 reset: sample=%0d active=%0b expected 0 0", sample_out, active);
        end
        check_rd(5'h15, 8'h00, 1);   // R1
        check_rd(5'h00, 8'hFF, 2);   // R2 control region reads ones

        // R2 fill sample store
        for (int i = 0; i < 16; i++) begin
            model_ram[i] = {4'(i), ~4'(i)};
            wr(5'(16 + i), model_ram[i]);
        end
        check_rd(5'h10, model_ram[0], 2);
        check_rd(5'h17, model_ram[7], 2);
        check_rd(5'h1F, model_ram[15], 2);

        cyc_en = 1'b1;
        // R3 / R5: period 2047 gives reload 2; run past the wrap
        wr(5'd0, 8'h80);
        wr(5'd2, 8'h20); model_lvl = 2'd1;
        wr(5'd3, 8'hFF);
        wr(5'd4, 8'h87); t = edge_n;
        push(t + 1, 3, 1'b1, 4'd0, 1'b1);
        play(t, 2, 40, 5);
        drain();

        // R4 / R10: retrigger with period 2046 (reload 4)
        wr(5'd3, 8'hFE);
        wr(5'd4, 8'h87); t = edge_n;
        push(t + 1, 10, 1'b1, 4'd0, 1'b1);
        play(t, 4, 10, 4);
        drain();
        // R4: top period bits from control: 0x6FE -> reload 516
        wr(5'd4, 8'h86); t = edge_n;
        play(t, 516, 3, 4);
        drain();
        wr(5'd3, 8'hFF);

        // R6 level codes
        for (int c = 3; c >= 0; c--) begin
            if (c == 1) continue;
            wr(5'd2, 8'(c << 5)); model_lvl = 2'(c);
            wr(5'd4, 8'h87); t = edge_n;
            play(t, 2, 8, 6);
            drain();
        end

        // R7 converter gating while position keeps advancing
        wr(5'd2, 8'h20); model_lvl = 2'd1;
        wr(5'd4, 8'h87); t = edge_n;
        wr(5'd0, 8'h00); d = edge_n;
        push(d + 1, 7, 1'b1, 4'd0, 1'b0);
        wr(5'd0, 8'h80); e = edge_n;
        k = 0;
        while (t + 3 + 2 * k <= e) k++;
        x = t + 3 + 2 * k;
        if (x > e + 1) push(e + 1, 7, 1'b1, 4'd0, 1'b1);
        push(x, 7, 1'b1, scaled(nib_of(k), model_lvl), 1'b1);
        drain();

        // R9 cycle enable low freezes playback
        @(negedge clk); cyc_en = 1'b0;
        wr(5'd4, 8'h87); t = edge_n;
        push(t + 1, 9, 1'b1, 4'd0, 1'b1);
        push(t + 20, 9, 1'b1, 4'd0, 1'b1);
        while (edge_n < t + 20) @(negedge clk);
        cyc_en = 1'b1;
        push(t + 22, 9, 1'b1, 4'd0, 1'b1);
        push(t + 23, 9, 1'b1, scaled(nib_of(0), model_lvl), 1'b1);
        drain();

        // R8 length counter with stop set
        wr(5'd1, 8'd254);
        wr(5'd4, 8'hC7);
        pulse_len(); d = edge_n;
        push(d + 1, 8, 1'b0, 4'd0, 1'b1);
        drain();
        pulse_len(); d = edge_n;
        push(d + 1, 8, 1'b1, 4'd0, 1'b0);
        drain();
        // R8 wrap without stop keeps running
        wr(5'd1, 8'd255);
        wr(5'd4, 8'h87);
        pulse_len(); d = edge_n;
        push(d + 1, 8, 1'b0, 4'd0, 1'b1);
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule